// File: doc/BRIEF.md
# Interrupt Priority and Acknowledge Unit

This unit is the request, in-service and vectoring core of an eight-line interrupt controller. It watches eight raw request pins for rising edges and records each accepted request in a pending register. When the processor could take a request, it raises a one-clock interrupt pulse. A separate command interface supplies the per-line mask, the vector base, the cascade map and the automatic end-of-interrupt option. The same interface delivers end-of-interrupt strobes, either for a named line or for the most urgent line in service.

When the processor strobes acknowledge, the unit picks the highest-numbered pending line. It moves that line into service, or retires it at once in automatic mode. One clock later it presents an 8-bit vector, or a flag meaning a cascaded controller on that line must supply the vector. The pending and in-service registers are visible as outputs for readback. A higher line number always means higher priority.

Top module: `irq_ack_core`

## Requirements
- R1: A request is registered only on a low-to-high transition of a pin (a pin high out of reset counts as a transition). A pin held high requests nothing further.
- R2: A rising edge on a line whose mask bit is 1 is discarded. The pending bit stays unchanged and no pulse is raised, and clearing the mask later does not revive the edge.
- R3: An unmasked rising edge on line n sets pending bit n in the next cycle. It raises the interrupt pulse only if no in-service bit at position n or above is set.
- R4: With automatic mode off, an acknowledge clears the highest-numbered pending bit and sets the in-service bit of that line.
- R5: With automatic mode on, an acknowledge clears the chosen pending bit and leaves the in-service register without it. If any request is still pending and no in-service bit at or above the highest pending line is set, the interrupt pulse is raised again.
- R6: In the cycle after an acknowledge, the valid flag is high and the vector equals the vector base ORed with the 3-bit number of the chosen line. The valid flag is low in every cycle that does not follow an acknowledge.
- R7: If the chosen line's bit in the cascade map is 1, the slave-supplies-vector flag is high together with the valid flag. Otherwise it is low.
- R8: A specific end-of-interrupt clears the in-service bit of the given line. If a request is still pending, the pulse is raised again only when no in-service bit at or above the highest pending line remains set.
- R9: A nonspecific end-of-interrupt clears the highest-numbered set in-service bit. If both kinds of end-of-interrupt are strobed together, the nonspecific one wins.
- R10: An acknowledge while nothing is pending returns the vector base ORed with line 0 and leaves the pending register, the in-service register and the slave flag at zero.
- R11: After reset the pending and in-service registers, the interrupt pulse, the valid flag and the slave flag are all zero.
- R12: Each signalling event gives an interrupt pulse exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_pins | input | 8 | Raw request pins, bit n is line n |
| mask_bits | input | 8 | Per-line mask, 1 discards edges |
| vec_base | input | 8 | Vector base ORed with the line number |
| cascade_map | input | 8 | 1 marks a line wired to a cascaded controller |
| auto_eoi | input | 1 | Retire the line at acknowledge time |
| eoi_spec | input | 1 | Strobe: end-of-interrupt for eoi_line |
| eoi_line | input | 3 | Line targeted by eoi_spec |
| eoi_nonspec | input | 1 | Strobe: end-of-interrupt for highest in-service line |
| ack | input | 1 | One-clock acknowledge strobe from the processor side |
| int_pulse | output | 1 | One-clock interrupt request to the processor |
| vec_out | output | 8 | Vector for the last acknowledge |
| vec_valid | output | 1 | vec_out and slave_vec are valid this cycle |
| slave_vec | output | 1 | A cascaded controller supplies the vector |
| irr_q | output | 8 | Pending request register |
| isr_q | output | 8 | In-service register |

## Verification
A corrupted pending or in-service bit shows up at the ports in one of two ways. The exported registers reveal it in the cycle after the faulty update. It also surfaces as a wrong line number in the low vector bits at the next acknowledge. A broken nesting check appears as an interrupt pulse raised or withheld in the cycle right after an edge, an acknowledge in automatic mode, or an end-of-interrupt. A wrong priority encoder appears in the vector and in which pending bit remains after the acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;

   // Which end-of-interrupt form is applied in a cycle
   typedef enum logic [1:0] {
      EOI_NONE    = 2'd0,
      EOI_BY_LINE = 2'd1,
      EOI_TOP     = 2'd2
   } eoi_kind_e;

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pins,
   output logic [WIDTH-1:0] rise
);

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pins;
   end

   assign rise = pins & ~prev_q;

   // R1
   rise_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rise & $past(pins)) == '0));

endmodule

// File: rtl/irq_msb_enc.sv
module irq_msb_enc #(
   parameter int WIDTH = 8,
   localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [WIDTH-1:0] bits_in,
   output logic [IDX_W-1:0] top_idx,
   output logic             any_set
);

   always_comb begin
      top_idx = '0;
      for (int i = 0; i < WIDTH; i++) begin
         if (bits_in[i]) top_idx = IDX_W'(i);
      end
   end

   assign any_set = |bits_in;

endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
   parameter int N_LINES = 8,
   parameter int VEC_W   = 8,
   localparam int LINE_W = $clog2(N_LINES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ack,
   input  logic               pend_any,
   input  logic [LINE_W-1:0]  pend_top,
   input  logic [VEC_W-1:0]   vec_base,
   input  logic [N_LINES-1:0] cascade_map,
   output logic [VEC_W-1:0]   vec_out,
   output logic               vec_valid,
   output logic               slave_vec
);

   logic [LINE_W-1:0] chosen;
   assign chosen = pend_any ? pend_top : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_out   <= '0;
         vec_valid <= 1'b0;
         slave_vec <= 1'b0;
      end else begin
         vec_valid <= ack;
         slave_vec <= ack & pend_any & cascade_map[chosen];
         if (ack) vec_out <= vec_base | VEC_W'(chosen);
      end
   end

   // R6
   ack_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> vec_valid);

   // R6
   no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack |=> !vec_valid);

   // R7
   slave_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slave_vec |-> vec_valid);

endmodule

// File: rtl/irq_ack_core.sv
module irq_ack_core #(
   parameter int N_LINES = 8,
   parameter int VEC_W   = 8,
   localparam int LINE_W = $clog2(N_LINES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] req_pins,
   input  logic [N_LINES-1:0] mask_bits,
   input  logic [VEC_W-1:0]   vec_base,
   input  logic [N_LINES-1:0] cascade_map,
   input  logic               auto_eoi,
   input  logic               eoi_spec,
   input  logic [LINE_W-1:0]  eoi_line,
   input  logic               eoi_nonspec,
   input  logic               ack,
   output logic               int_pulse,
   output logic [VEC_W-1:0]   vec_out,
   output logic               vec_valid,
   output logic               slave_vec,
   output logic [N_LINES-1:0] irr_q,
   output logic [N_LINES-1:0] isr_q
);
   import irq_pkg::*;

   // Elaboration-time parameter checks
   if (N_LINES < 2 || (N_LINES & (N_LINES - 1)) != 0) begin : g_bad_lines
      $error("irq_ack_core: N_LINES must be a power of two, at least 2");
   end
   if (VEC_W < LINE_W) begin : g_bad_vec
      $error("irq_ack_core: VEC_W must hold a line number");
   end

   logic [N_LINES-1:0] rise;
   logic [LINE_W-1:0]  irr_top, isr_top, nxt_top;
   logic               irr_any, isr_any, nxt_any;
   logic [N_LINES-1:0] irr_nxt, isr_nxt, isr_after_eoi;
   logic [N_LINES-1:0] eoi_clr, ack_bit, accepted, hi_free;
   logic               ack_take, resig, edge_fire, pulse_d;
   eoi_kind_e          eoi_kind;

   irq_edge_det #(.WIDTH(N_LINES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pins(req_pins), .rise(rise)
   );

   irq_msb_enc #(.WIDTH(N_LINES)) u_irr_enc (
      .bits_in(irr_q), .top_idx(irr_top), .any_set(irr_any)
   );

   irq_msb_enc #(.WIDTH(N_LINES)) u_isr_enc (
      .bits_in(isr_q), .top_idx(isr_top), .any_set(isr_any)
   );

   irq_msb_enc #(.WIDTH(N_LINES)) u_nxt_enc (
      .bits_in(irr_nxt), .top_idx(nxt_top), .any_set(nxt_any)
   );

   // End-of-interrupt selection
   always_comb begin
      if (eoi_nonspec)   eoi_kind = EOI_TOP;
      else if (eoi_spec) eoi_kind = EOI_BY_LINE;
      else               eoi_kind = EOI_NONE;
      unique case (eoi_kind)
         EOI_TOP:     eoi_clr = isr_any ? (N_LINES'(1) << isr_top) : '0;
         EOI_BY_LINE: eoi_clr = N_LINES'(1) << eoi_line;
         default:     eoi_clr = '0;
      endcase
   end

   assign isr_after_eoi = isr_q & ~eoi_clr;

   // Acknowledge: highest pending line
   assign ack_take = ack & irr_any;
   assign ack_bit  = ack_take ? (N_LINES'(1) << irr_top) : '0;
   assign accepted = rise & ~mask_bits;

   assign irr_nxt = (irr_q & ~ack_bit) | accepted;
   assign isr_nxt = auto_eoi ? (isr_after_eoi & ~ack_bit)
                             : (isr_after_eoi | ack_bit);

   // A line may signal only when nothing at or above it is in service
   for (genvar g = 0; g < N_LINES; g++) begin : g_free
      assign hi_free[g] = ~|isr_nxt[N_LINES-1:g];
   end

   assign edge_fire = |(accepted & hi_free);
   assign resig     = ((eoi_kind != EOI_NONE) | (ack_take & auto_eoi))
                      & nxt_any & hi_free[nxt_top];
   assign pulse_d   = edge_fire | resig;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr_q     <= '0;
         isr_q     <= '0;
         int_pulse <= 1'b0;
      end else begin
         irr_q     <= irr_nxt;
         isr_q     <= isr_nxt;
         int_pulse <= pulse_d;
      end
   end

   irq_vec_gen #(.N_LINES(N_LINES), .VEC_W(VEC_W)) u_vec (
      .clk(clk), .rst_n(rst_n), .ack(ack),
      .pend_any(irr_any), .pend_top(irr_top),
      .vec_base(vec_base), .cascade_map(cascade_map),
      .vec_out(vec_out), .vec_valid(vec_valid), .slave_vec(slave_vec)
   );

   // R2
   masked_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((irr_q & ~$past(irr_q) & $past(mask_bits)) == '0));

   // R4
   ack_enters_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irr_q != '0 && !auto_eoi && !eoi_spec && !eoi_nonspec)
      |=> (isr_q != '0));

   // R5
   auto_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && auto_eoi) |=> ($countones(isr_q) <= $countones($past(isr_q))));

   // R10
   empty_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irr_q == '0 && !eoi_spec && !eoi_nonspec)
      |=> ($stable(isr_q) && !slave_vec));

endmodule

// File: tb/test_irq_ack_core.sv
module test_irq_ack_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req_pins = '0, mask_bits = '0, vec_base = 8'hA8, cascade_map = '0;
   logic       auto_eoi = 1'b0, eoi_spec = 1'b0, eoi_nonspec = 1'b0, ack = 1'b0;
   logic [2:0] eoi_line = '0;
   logic       int_pulse, vec_valid, slave_vec;
   logic [7:0] vec_out, irr_q, isr_q;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   irq_ack_core i_irq_ack_core (
      .clk(clk), .rst_n(rst_n), .req_pins(req_pins), .mask_bits(mask_bits),
      .vec_base(vec_base), .cascade_map(cascade_map), .auto_eoi(auto_eoi),
      .eoi_spec(eoi_spec), .eoi_line(eoi_line), .eoi_nonspec(eoi_nonspec),
      .ack(ack), .int_pulse(int_pulse), .vec_out(vec_out),
      .vec_valid(vec_valid), .slave_vec(slave_vec), .irr_q(irr_q), .isr_q(isr_q)
   );

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_ack();
      ack = 1'b1;
      step();
      ack = 1'b0;
   endtask

   task automatic t_reset();
      chk("R11", "irr", irr_q, 8'h00);
      chk("R11", "isr", isr_q, 8'h00);
      chk("R11", "pulse", {7'd0, int_pulse}, 8'h00);
      chk("R11", "valid", {7'd0, vec_valid}, 8'h00);
      chk("R11", "slave", {7'd0, slave_vec}, 8'h00);
   endtask

   task automatic t_edge();
      req_pins = 8'h08; step();
      chk("R3", "irr after edge", irr_q, 8'h08);
      chk("R3", "pulse after edge", {7'd0, int_pulse}, 8'h01);
      step();
      chk("R12", "pulse one cycle", {7'd0, int_pulse}, 8'h00);
      chk("R1", "held pin irr", irr_q, 8'h08);
      do_ack();
      chk("R6", "vector line 3", vec_out, 8'hAB);
      chk("R6", "valid", {7'd0, vec_valid}, 8'h01);
      chk("R7", "no slave", {7'd0, slave_vec}, 8'h00);
      chk("R4", "irr cleared", irr_q, 8'h00);
      chk("R4", "isr set", isr_q, 8'h08);
      step();
      chk("R6", "valid drops", {7'd0, vec_valid}, 8'h00);
      req_pins = 8'h00; step();
   endtask

   task automatic t_masked();
      mask_bits = 8'h20; req_pins = 8'h20; step();
      chk("R2", "masked irr", irr_q, 8'h00);
      chk("R2", "masked pulse", {7'd0, int_pulse}, 8'h00);
      mask_bits = 8'h00; step();
      chk("R2", "unmask no revive", irr_q, 8'h00);
      chk("R2", "isr untouched", isr_q, 8'h08);
      req_pins = 8'h00; step();
   endtask

   task automatic t_nested();
      req_pins = 8'h02; step();
      chk("R3", "low line pending", irr_q, 8'h02);
      chk("R3", "low line blocked", {7'd0, int_pulse}, 8'h00);
      req_pins = 8'h42; step();
      chk("R3", "high line pending", irr_q, 8'h42);
      chk("R3", "high line pulses", {7'd0, int_pulse}, 8'h01);
      do_ack();
      chk("R4", "highest chosen", vec_out, 8'hAE);
      chk("R4", "low left pending", irr_q, 8'h02);
      chk("R4", "two in service", isr_q, 8'h48);
      req_pins = 8'h00;
   endtask

   task automatic t_eoi_nonspec();
      eoi_nonspec = 1'b1; step(); eoi_nonspec = 1'b0;
      chk("R9", "top isr cleared", isr_q, 8'h08);
      chk("R8", "resignal blocked", {7'd0, int_pulse}, 8'h00);
      eoi_nonspec = 1'b1; step(); eoi_nonspec = 1'b0;
      chk("R9", "next isr cleared", isr_q, 8'h00);
      chk("R8", "resignal raised", {7'd0, int_pulse}, 8'h01);
      do_ack();
      chk("R6", "vector line 1", vec_out, 8'hA9);
      chk("R4", "line 1 in service", isr_q, 8'h02);
      chk("R4", "nothing pending", irr_q, 8'h00);
   endtask

   task automatic t_eoi_spec();
      eoi_line = 3'd1; eoi_spec = 1'b1; step(); eoi_spec = 1'b0;
      chk("R8", "specific clear", isr_q, 8'h00);
      chk("R8", "no pending no pulse", {7'd0, int_pulse}, 8'h00);
   endtask

   task automatic t_empty();
      vec_base = 8'h40;
      do_ack();
      chk("R10", "base vector", vec_out, 8'h40);
      chk("R10", "valid", {7'd0, vec_valid}, 8'h01);
      chk("R10", "no slave", {7'd0, slave_vec}, 8'h00);
      chk("R10", "irr", irr_q, 8'h00);
      chk("R10", "isr", isr_q, 8'h00);
   endtask

   task automatic t_cascade();
      cascade_map = 8'h10; req_pins = 8'h10; step();
      chk("R3", "cascade line pulse", {7'd0, int_pulse}, 8'h01);
      do_ack();
      chk("R7", "slave flag", {7'd0, slave_vec}, 8'h01);
      chk("R7", "valid with slave", {7'd0, vec_valid}, 8'h01);
      chk("R4", "isr line 4", isr_q, 8'h10);
      eoi_line = 3'd4; eoi_spec = 1'b1; step(); eoi_spec = 1'b0;
      chk("R8", "line 4 retired", isr_q, 8'h00);
      req_pins = 8'h00; cascade_map = 8'h00; step();
   endtask

   task automatic t_auto();
      auto_eoi = 1'b1; req_pins = 8'h84; step();
      chk("R3", "two edges pending", irr_q, 8'h84);
      chk("R3", "two edges pulse", {7'd0, int_pulse}, 8'h01);
      do_ack();
      chk("R5", "auto vector 7", vec_out, 8'h47);
      chk("R5", "auto isr empty", isr_q, 8'h00);
      chk("R5", "auto irr left", irr_q, 8'h04);
      chk("R5", "auto resignal", {7'd0, int_pulse}, 8'h01);
      do_ack();
      chk("R5", "auto vector 2", vec_out, 8'h42);
      chk("R5", "auto drained", irr_q, 8'h00);
      chk("R5", "no resignal", {7'd0, int_pulse}, 8'h00);
      req_pins = 8'h00; auto_eoi = 1'b0; step();
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_edge();
      t_masked();
      t_nested();
      t_eoi_nonspec();
      t_eoi_spec();
      t_empty();
      t_cascade();
      t_auto();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule